// File: doc/BRIEF.md
# Configurable-Phase Byte SPI Master

This block is the controller side of a four-wire serial link. It moves one 8-bit byte out on the data-out line and, at the same time, one byte in from the data-in line, most significant bit first. Two configuration bits choose the clock timing. The first bit sets the level the serial clock rests at. The second bit names the clock edge on which outgoing data changes. A value of 1 means the data changes as the clock returns to its resting level. A value of 0 means it changes as the clock leaves that level. The edge-select bit is therefore the inverse of the usual phase bit: rest-low with edge-select 1 gives the common mode 0 timing.

A one-cycle `start_i` pulse begins a transfer. Software supplies the byte, the two timing bits and a half-period count. The block drives chip select low and waits one half period. It then produces sixteen clock edges, one per half period, and waits one more half period before it releases chip select. The received byte appears with a one-cycle `done_o` pulse. The divider is 16 bits wide, so a 100 MHz system clock can run the link at about 25 kHz to probe an unknown slave with `0xFF` dummy bytes. The same divider also reaches rates of several MHz. The data-out line rests high whenever no byte is being sent.

Top module: `spi_byte_master`

## Requirements
- R1: Whenever `busy_o` is low, `sck_o` rests at the level given by `cfg_ckp_i` (0 = low, 1 = high), following it within one clock. During a transfer it returns to the captured level before chip select is released.
- R2: With `cfg_cke_i` = 1, the first data bit is on `mosi_o` from the clock in which `cs_n_o` falls. `mosi_o` changes only on edges that return `sck_o` to its resting level, and `miso_i` is sampled on edges that leave it. With rest-low this is mode 0.
- R3: With `cfg_cke_i` = 0, `mosi_o` stays high until the first `sck_o` edge. It then changes only on edges that leave the resting level, and `miso_i` is sampled on edges that return to it.
- R4: `mosi_o` is high whenever `busy_o` is low. A transfer of `0xFF` keeps `mosi_o` high for its whole duration.
- R5: Every `sck_o` edge, and the gaps before the first edge and after the last, last H = `cfg_div_i` + 1 system clocks.
- R6: `cs_n_o` (active low) falls one clock after `start_i` is accepted. The first `sck_o` edge follows H clocks later, exactly 16 edges are produced, and `cs_n_o` rises H clocks after the last edge.
- R7: Both the transmitted and the received byte travel most significant bit first.
- R8: `done_o` is a single-cycle pulse one system clock after the eighth sampling edge. `rx_data_o` holds the received byte from then until the next `done_o`.
- R9: `busy_o` is high from the clock after an accepted start until `cs_n_o` rises. A `start_i` that arrives while `busy_o` is high is ignored.
- R10: The timing bits, the divider and the transmit byte are captured at the accepted start. Changes to them during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ckp_i | input | 1 | Clock resting level (0 low, 1 high) |
| cfg_cke_i | input | 1 | Output edge: 1 = change on return to rest, 0 = change on leaving rest |
| cfg_div_i | input | DIV_W | Half-period length minus one, in system clocks |
| start_i | input | 1 | Start pulse, accepted only while idle |
| tx_data_i | input | BYTE_W | Byte to transmit |
| rx_data_o | output | BYTE_W | Last received byte |
| done_o | output | 1 | One-cycle pulse when a byte has been received |
| busy_o | output | 1 | Transfer in progress |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench targets edge-to-data alignment in all four clock settings. A design that treated the edge-select bit as the ordinary phase bit would change `mosi_o` on the sampling edge, and a bench slave acting on the requirement's edges would then capture a shifted byte. The bench measures the gaps from chip-select fall to the first edge and from the last edge to release, with the divider at its fastest and at a 2000-clock setting. An off-by-one in the divider or an extra edge before the first bit shows up in those gaps or in the edge count. Part-way through one transfer it pulses start and flips every configuration input, so a design that restarted or re-read its configuration would show a wrong edge count or wrong bytes. It also times `done_o` against the eighth sampling edge, which falls on a different edge in the two phase settings.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_LEAD = 2'd1,
        XS_RUN  = 2'd2,
        XS_TAIL = 2'd3
    } xfer_state_e;

    // Number of clock edges in a frame of the given byte width.
    function automatic int frame_edges(input int bits);
        return 2 * bits;
    endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] count;
    } tick_regs_t;

    tick_regs_t r_q, r_d;
    logic       at_limit;

    assign at_limit = (r_q.count == limit_i);
    assign tick_o   = run_i && at_limit;

    always_comb begin
        r_d = r_q;
        if (!run_i || at_limit) begin
            r_d.count = '0;
        end else begin
            r_d.count = r_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && $past(run_i) && $stable(limit_i) |-> r_q.count <= limit_i); // R5

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              early_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic              out_shift_i,
    input  logic              in_shift_i,
    input  logic              miso_i,
    output logic              bit_o,
    output logic [BYTE_W-1:0] rx_o
);

    localparam int SH_W = BYTE_W + 1;

    typedef struct packed {
        logic [SH_W-1:0]   sh;
        logic [BYTE_W-1:0] rx;
    } shift_regs_t;

    shift_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            // early: first bit on the line at once; otherwise a leading 1 holds the line high
            r_d.sh = early_i ? {tx_i, 1'b1} : {1'b1, tx_i};
        end else if (out_shift_i) begin
            r_d.sh = {r_q.sh[SH_W-2:0], 1'b1};
        end
        if (in_shift_i) begin
            r_d.rx = {r_q.rx[BYTE_W-2:0], miso_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_o = r_q.sh[SH_W-1];
    assign rx_o  = r_q.rx;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_cfg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_ckp_i,
    input  logic              cfg_cke_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);

    localparam int EDGE_N = frame_edges(BYTE_W);
    localparam int EW     = $clog2(EDGE_N);
    localparam int SW     = $clog2(BYTE_W + 1);

    typedef struct packed {
        xfer_state_e       state;
        logic              ckp;
        logic              cke;
        logic [DIV_W-1:0]  div;
        logic              sck;
        logic [EW-1:0]     edge_ix;
        logic [SW-1:0]     samples;
        logic              pend;
        logic              done;
        logic [BYTE_W-1:0] rx;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    logic              tick;
    logic              run;
    logic              accept;
    logic              edge_fire;
    logic              leading;
    logic              out_shift;
    logic              in_shift;
    logic              shift_bit;
    logic [BYTE_W-1:0] shift_rx;

    assign run       = (r_q.state != XS_IDLE);
    assign accept    = (r_q.state == XS_IDLE) && start_i;
    assign edge_fire = tick && ((r_q.state == XS_LEAD) || (r_q.state == XS_RUN));
    assign leading   = ~r_q.edge_ix[0];
    assign out_shift = edge_fire && (r_q.cke ? !leading : leading);
    assign in_shift  = edge_fire && (r_q.cke ? leading : !leading);

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .limit_i (r_q.div),
        .tick_o  (tick)
    );

    spi_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (accept),
        .early_i     (cfg_cke_i),
        .tx_i        (tx_data_i),
        .out_shift_i (out_shift),
        .in_shift_i  (in_shift),
        .miso_i      (miso_i),
        .bit_o       (shift_bit),
        .rx_o        (shift_rx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.pend = 1'b0;

        unique case (r_q.state)
            XS_IDLE: begin
                r_d.sck = cfg_ckp_i;
                if (start_i) begin
                    r_d.state   = XS_LEAD;
                    r_d.ckp     = cfg_ckp_i;
                    r_d.cke     = cfg_cke_i;
                    r_d.div     = cfg_div_i;
                    r_d.edge_ix = '0;
                    r_d.samples = '0;
                end
            end
            XS_LEAD, XS_RUN: begin
                if (edge_fire) begin
                    r_d.sck     = ~r_q.sck;
                    r_d.edge_ix = r_q.edge_ix + 1'b1;
                    r_d.state   = (r_q.edge_ix == EW'(EDGE_N - 1)) ? XS_TAIL : XS_RUN;
                end
            end
            XS_TAIL: begin
                if (tick) begin
                    r_d.state = XS_IDLE;
                end
            end
            default: r_d.state = XS_IDLE;
        endcase

        if (in_shift) begin
            r_d.samples = r_q.samples + 1'b1;
            r_d.pend    = (r_q.samples == SW'(BYTE_W - 1));
        end
        if (r_q.pend) begin
            r_d.done = 1'b1;
            r_d.rx   = shift_rx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= XS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = run;
    assign cs_n_o    = !run;
    assign sck_o     = r_q.sck;
    assign mosi_o    = run ? shift_bit : 1'b1;
    assign done_o    = r_q.done;
    assign rx_data_o = r_q.rx;

    AST_MOSI_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) && !$stable(mosi_o) |-> !$stable(sck_o)); // R2
    AST_CKE1_TRAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) && r_q.cke && !$stable(mosi_o) |-> sck_o == r_q.ckp); // R2
    AST_CKE0_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) && !r_q.cke && !$stable(mosi_o) |-> sck_o != r_q.ckp); // R3
    AST_SCK_RESTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(sck_o) == r_q.ckp); // R1
    AST_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) && !$stable(sck_o) |-> $past(tick)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && start_i |=> $stable(r_q.div) && $stable(r_q.cke) && $stable(r_q.ckp)); // R9

endmodule

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ckp = 1'b0;
    logic        cfg_cke = 1'b1;
    logic [15:0] cfg_div = 16'd0;
    logic        start = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic [7:0]  rx_data;
    logic        done;
    logic        busy;
    logic        cs_n;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b1;

    int tests = 0;
    int fails = 0;

    logic [7:0] exp_rx[$];

    // slave model state
    logic       t_ckp = 1'b0;
    logic       t_cke = 1'b1;
    logic [7:0] sl_byte = 8'h00;
    logic [7:0] sl_sh = 8'h00;
    logic [7:0] sl_rx = 8'h00;

    always #4 clk = ~clk;

    spi_byte_master uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cfg_ckp_i (cfg_ckp),
        .cfg_cke_i (cfg_cke),
        .cfg_div_i (cfg_div),
        .start_i   (start),
        .tx_data_i (tx_data),
        .rx_data_o (rx_data),
        .done_o    (done),
        .busy_o    (busy),
        .cs_n_o    (cs_n),
        .sck_o     (sck),
        .mosi_o    (mosi),
        .miso_i    (miso)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Slave model acting on the requirement's edges
    always @(negedge cs_n) begin
        sl_sh = sl_byte;
        sl_rx = 8'h00;
        if (t_cke) miso = sl_sh[7];
    end

    always @(sck) begin
        if (!cs_n) begin
            if ((sck != t_ckp) == t_cke) begin
                sl_rx = {sl_rx[6:0], mosi};
            end else if (t_cke) begin
                sl_sh = {sl_sh[6:0], 1'b1};
                miso  = sl_sh[7];
            end else begin
                miso  = sl_sh[7];
                sl_sh = {sl_sh[6:0], 1'b1};
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_rx.size() == 0) begin
                chk(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                chk(rx_data == e, "R7", "received byte", rx_data, e);
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input logic ckp,
                        input logic cke, input logic [15:0] div, input bit poke);
        int t = 0, nedges = 0, first_edge = -1, last_edge = -1, samples = 0;
        int last_samp = -1, done_at = -1, bad_mosi = 0, bad_busy = 0, low_mosi = 0;
        bit done_wide = 0, poked = 0, restore = 0;
        logic prev_sck, prev_mosi, prev_busy, prev_done;
        int h = int'(div) + 1;
        cfg_ckp = ckp; cfg_cke = cke; cfg_div = div;
        t_ckp = ckp; t_cke = cke; sl_byte = sl;
        @(negedge clk);
        exp_rx.push_back(sl);
        tx_data = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b0, "R6", "cs_n one clock after start", cs_n, 0);
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        if (cke) chk(mosi == tx[7], "R2", "first bit before first edge", mosi, tx[7]);
        else     chk(mosi == 1'b1, "R3", "mosi high before first edge", mosi, 1);
        prev_sck = sck; prev_mosi = mosi; prev_busy = busy; prev_done = done;
        while (!cs_n && t < 100000) begin
            @(negedge clk);
            t++;
            if (restore) begin
                start = 1'b0; tx_data = tx; cfg_ckp = ckp; cfg_cke = cke; cfg_div = div;
                restore = 0;
            end
            if (!cs_n && !busy) bad_busy++;
            if (!cs_n && !mosi) low_mosi++;
            if (sck != prev_sck) begin
                nedges++;
                if (first_edge < 0) first_edge = t;
                last_edge = t;
                if ((((nedges - 1) % 2) == 0) == cke) begin
                    samples++;
                    if (samples == 8) last_samp = t;
                end
            end
            if (busy && prev_busy && mosi != prev_mosi) begin
                if (!(sck != prev_sck && (cke ? (sck == ckp) : (sck != ckp)))) bad_mosi++;
            end
            if (done) begin
                if (prev_done) done_wide = 1;
                done_at = t;
            end
            if (poke && !poked && nedges == 5) begin
                // R9 R10: start and new settings mid-transfer
                start = 1'b1; tx_data = ~tx; cfg_ckp = ~ckp; cfg_cke = ~cke; cfg_div = div + 16'd3;
                poked = 1; restore = 1;
            end
            prev_sck = sck; prev_mosi = mosi; prev_busy = busy; prev_done = done;
        end
        chk(busy == 1'b0, "R9", "busy falls with cs_n", busy, 0);
        chk(bad_busy == 0, "R9", "busy low inside frame", bad_busy, 0);
        chk(nedges == 16, "R6", "edge count", nedges, 16);
        chk(first_edge == h, "R5", "cs fall to first edge", first_edge, h);
        chk(t - last_edge == h, "R6", "last edge to cs rise", t - last_edge, h);
        chk(bad_mosi == 0, cke ? "R2" : "R3", "mosi change on wrong edge", bad_mosi, 0);
        chk(sl_rx == tx, "R7", "slave received byte", sl_rx, tx);
        chk(done_at == last_samp + 1, "R8", "done timing", done_at, last_samp + 1);
        chk(!done_wide, "R8", "done width", done_wide, 0);
        if (tx == 8'hFF) chk(low_mosi == 0, "R4", "dummy byte keeps mosi high", low_mosi, 0);
        if (poke) chk(poked, "R10", "mid-transfer poke applied", poked, 1);
        @(negedge clk);
        chk(mosi == 1'b1, "R4", "mosi idle", mosi, 1);
        chk(sck == ckp, "R1", "sck rest level", sck, ckp);
        chk(rx_data == sl, "R8", "rx held after done", rx_data, sl);
    endtask

    initial begin
        #(200000 * 8);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R9", "reset cs_n", cs_n, 1);
        chk(busy == 1'b0, "R9", "reset busy", busy, 0);
        chk(mosi == 1'b1, "R4", "reset mosi", mosi, 1);
        chk(sck == 1'b0, "R1", "reset sck", sck, 0);
        chk(done == 1'b0, "R8", "reset done", done, 0);

        xfer(8'hA5, 8'h3C, 1'b0, 1'b1, 16'd3, 1'b0);   // mode 0
        xfer(8'h81, 8'h7E, 1'b1, 1'b1, 16'd2, 1'b0);   // rest high, change on return
        xfer(8'h5A, 8'hC3, 1'b0, 1'b0, 16'd0, 1'b0);   // rest low, change on leave
        xfer(8'hF0, 8'h0F, 1'b1, 1'b0, 16'd1, 1'b0);   // mode 3
        xfer(8'hFF, 8'h96, 1'b0, 1'b1, 16'd1999, 1'b0); // slow dummy probe
        xfer(8'h3C, 8'hA5, 1'b0, 1'b1, 16'd4, 1'b1);   // poke mid-transfer
        xfer(8'h01, 8'h80, 1'b1, 1'b0, 16'd0, 1'b0);

        // R1: idle level follows the setting while idle
        cfg_ckp = 1'b1;
        repeat (2) @(negedge clk);
        chk(sck == 1'b1, "R1", "idle sck follows setting", sck, 1);
        chk(exp_rx.size() == 0, "R8", "all expected bytes seen", exp_rx.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule